// File: doc/BRIEF.md
# Test-Verdict Fault Diagnosis Engine

This block turns a complete set of mutual test verdicts from an N-unit system into a list of faulty units. Each unit tests the T units that follow it around a ring (unit i tests units i+1 to i+T, modulo N). A unit that is working always reports the true state of the unit it tests. A faulty unit may report anything. The verdicts arrive as one flattened matrix together with a start strobe. The engine then searches every fault hypothesis that has at most T members. It keeps the hypotheses that agree with every verdict issued by a tester the hypothesis assumes to be good.

The search takes one candidate per clock cycle, in ascending binary order of the candidate bitmap, and covers all 2^N bitmaps. Any bitmap with more than T members is rejected as a contradiction. At the end the engine pulses `done` and presents the result:
- the unique consistent fault set, or
- a flag saying that no set fits, or
- a flag saying that several sets fit, with the first one found on the bitmap.

Parameter sets with fewer than 2T+1 units, or with T below 1, are refused at elaboration.

Top module: `pmc_diag_engine`

## Requirements
- R1: Verdict bit i*N+j of `verdicts` is unit i's opinion of unit j: 1 means failed, 0 means passed. For any true fault set of at most T units whose good testers report the truth, `faulty` equals that set after the search (bit k set means unit k is faulty). The all-zero matrix yields an empty bitmap.
- R2: Entries that are on the diagonal (i==j), or that are outside the ring assignment (j not in i+1..i+T mod N), have no effect on the result.
- R3: Verdicts issued by units inside the true fault set have no effect on the result, whatever their values.
- R4: When no candidate of at most T units is consistent, `none_found` is 1, `ambiguous` is 0 and `faulty` is all zeros.
- R5: `ambiguous` is set only when more than one candidate is consistent, and `faulty` then holds the lowest such bitmap. With legal parameters no verdict matrix gives two consistent candidates, so `ambiguous` stays 0.
- R6: `done` is high for exactly one cycle. It rises 2^N clock cycles after the rising edge that accepts `start`.
- R7: The block captures `verdicts` at the edge that accepts `start`. Later changes on `verdicts`, and `start` pulses during a search, have no effect on the timing or the result of that search.
- R8: `faulty`, `none_found` and `ambiguous` keep their values after `done` until the next search completes.
- R9: After reset, `done`, `faulty`, `none_found` and `ambiguous` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search; accepted only when idle |
| verdicts | input | N*N | Flattened verdict matrix, bit i*N+j = unit i about unit j |
| faulty | output | N | Diagnosed fault bitmap |
| done | output | 1 | One-cycle pulse at the end of a search |
| none_found | output | 1 | No candidate of at most T units is consistent |
| ambiguous | output | 1 | More than one consistent candidate was found |

## Verification
The hardest state to reach from the ports is one where faulty testers send misleading verdicts and the correct answer must still come out. The bench reaches it by building, for every single and double fault set, matrices in which:
- good testers tell the truth, and
- faulty testers, the diagonal and the untested entries are drawn at random, several times per set.

The results are compared against both the known fault set and an independent consistency model. Triple faults and a hand-built all-ones matrix drive the search into the no-consistent-set outcome. A start pulse and a changed matrix issued in the middle of a scan check that an in-flight search cannot be disturbed.

// File: rtl/diag_pkg.sv
package diag_pkg;
  localparam int MAX_N = 32;
  typedef logic [MAX_N-1:0]       mask_t;
  typedef logic [MAX_N*MAX_N-1:0] vmat_t;

  // Candidate is small enough to be a legal hypothesis.
  function automatic logic fits(input mask_t m, input int t);
    return ($countones(m) <= t);
  endfunction

  // Every verdict from a tester outside the candidate must equal the
  // testee's membership in the candidate.
  function automatic logic agrees(input vmat_t v, input mask_t m,
                                  input int n, input int t);
    logic good;
    good = 1'b1;
    for (int i = 0; i < n; i++) begin
      for (int k = 1; k <= t; k++) begin
        int j;
        j = (i + k) % n;
        if (!m[i] && (v[i*n+j] != m[j])) good = 1'b0;
      end
    end
    return good;
  endfunction
endpackage

// File: rtl/diag_cand_gen.sv
module diag_cand_gen #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  output logic [N-1:0] cand,
  output logic         busy,
  output logic         last
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cand <= '0;
    end else if (go) begin
      busy <= 1'b1;
      cand <= '0;
    end else if (busy) begin
      if (last) busy <= 1'b0;
      else      cand <= cand + 1'b1;
    end
  end

  assign last = busy && (&cand);

  // Candidates advance by exactly one per cycle during a scan.
  assert_cand_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> (cand == $past(cand) + 1'b1));

  // A scan cannot be restarted or cut short before its last candidate.
  assert_scan_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> busy);
endmodule

// File: rtl/diag_consist.sv
module diag_consist #(
  parameter int N = 5,
  parameter int T = 2
) (
  input  logic [N-1:0]   cand,
  input  logic [N*N-1:0] verd,
  output logic           size_ok,
  output logic           agree,
  output logic           ok
);
  import diag_pkg::*;

  mask_t m;
  vmat_t vm;

  always_comb begin
    m  = '0;
    vm = '0;
    m[N-1:0]    = cand;
    vm[N*N-1:0] = verd;
    size_ok = fits(m, T);
    agree   = agrees(vm, m, N, T);
    ok      = size_ok && agree;
  end
endmodule

// File: rtl/diag_tally.sv
module diag_tally #(
  parameter int N = 5,
  parameter int T = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         step,
  input  logic         last,
  input  logic         ok,
  input  logic [N-1:0] cand,
  output logic [N-1:0] faulty,
  output logic         none_found,
  output logic         ambiguous,
  output logic         done
);
  logic [1:0]   hits, hits_n;
  logic [N-1:0] first, first_n;
  logic         finish;

  always_comb begin
    hits_n  = hits;
    first_n = first;
    if (ok) begin
      if (hits == 2'd0) first_n = cand;
      if (hits != 2'd2) hits_n = hits + 2'd1;
    end
  end

  assign finish = step && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hits       <= '0;
      first      <= '0;
      faulty     <= '0;
      none_found <= 1'b0;
      ambiguous  <= 1'b0;
      done       <= 1'b0;
    end else begin
      done <= finish;
      if (clear) begin
        hits  <= '0;
        first <= '0;
      end else if (step) begin
        hits  <= hits_n;
        first <= first_n;
      end
      if (finish) begin
        faulty     <= (hits_n == 2'd0) ? '0 : first_n;
        none_found <= (hits_n == 2'd0);
        ambiguous  <= (hits_n == 2'd2);
      end
    end
  end

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(none_found && ambiguous));

  assert_none_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    none_found |-> (faulty == '0));

  assert_result_size_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones(faulty) <= T));

  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !finish |=> ($stable(faulty) && $stable(none_found) && $stable(ambiguous)));
endmodule

// File: rtl/pmc_diag_engine.sv
module pmc_diag_engine #(
  parameter int N = 5,
  parameter int T = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N*N-1:0] verdicts,
  output logic [N-1:0]   faulty,
  output logic           done,
  output logic           none_found,
  output logic           ambiguous
);
  localparam int NN = N * N;

  if (T < 1 || N < 2*T + 1 || N > diag_pkg::MAX_N) begin : g_bad_params
    $error("pmc_diag_engine: need T>=1 and 2T+1 <= N <= 32");
  end

  logic          busy, last, go;
  logic [N-1:0]  cand;
  logic [NN-1:0] verd_q;
  logic          size_ok, agree, cand_ok;

  assign go = start && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n)  verd_q <= '0;
    else if (go) verd_q <= verdicts;
  end

  diag_cand_gen #(.N(N)) u_gen (
    .clk(clk), .rst_n(rst_n), .go(go),
    .cand(cand), .busy(busy), .last(last)
  );

  diag_consist #(.N(N), .T(T)) u_chk (
    .cand(cand), .verd(verd_q),
    .size_ok(size_ok), .agree(agree), .ok(cand_ok)
  );

  diag_tally #(.N(N), .T(T)) u_tally (
    .clk(clk), .rst_n(rst_n), .clear(go), .step(busy), .last(last),
    .ok(cand_ok), .cand(cand),
    .faulty(faulty), .none_found(none_found), .ambiguous(ambiguous),
    .done(done)
  );

  // The captured matrix cannot move while a scan is running.
  assert_verd_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> $stable(verd_q));

  // The empty hypothesis always fits an all-pass matrix.
  assert_empty_fits_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cand == '0 && verd_q == '0) |-> cand_ok);
endmodule

// File: tb/test_pmc_diag_engine.sv
`timescale 1ns/1ps
module test_pmc_diag_engine;
  localparam int N  = 5;
  localparam int T  = 2;
  localparam int NN = N * N;
  localparam int LAT = 1 << N;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [NN-1:0] verdicts = '0;
  logic [N-1:0]  faulty;
  logic          done, none_found, ambiguous;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  pmc_diag_engine #(.N(N), .T(T)) i_pmc_diag_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .verdicts(verdicts),
    .faulty(faulty), .done(done), .none_found(none_found),
    .ambiguous(ambiguous)
  );

  // Directed vectors: matrix, expected bitmap, expected no-fit flag.
  localparam logic [NN-1:0] TV_VERD [5] = '{
    25'h0000000,   // all pass                    R1
    25'h1FFFFFF,   // all fail: nothing fits      R4
    25'h0108000,   // unit 0 faulty               R1
    25'h1F87C84,   // units 2,4 faulty, liars     R3
    25'h1041059    // diagonal and untested only  R2
  };
  localparam logic [N-1:0] TV_MAP  [5] = '{5'b00000, 5'b00000, 5'b00001, 5'b10100, 5'b00000};
  localparam logic         TV_NONE [5] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0};

  task automatic check(input bit cond, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Independent model: walks testees and derives each tester backwards.
  task automatic ref_eval(input logic [NN-1:0] v, output logic [N-1:0] m,
                          output bit nf, output bit am);
    int hits;
    hits = 0; m = '0;
    for (int mk = 0; mk < (1 << N); mk++) begin
      logic [N-1:0] s;
      bit fit;
      s = mk[N-1:0];
      fit = ($countones(s) <= T);
      for (int j = 0; j < N; j++)
        for (int k = 1; k <= T; k++) begin
          int tr;
          tr = (j - k + N) % N;
          if (!s[tr] && v[tr*N+j] != s[j]) fit = 0;
        end
      if (fit) begin
        if (hits == 0) m = s;
        hits++;
      end
    end
    nf = (hits == 0);
    am = (hits > 1);
    if (nf) m = '0;
  endtask

  function automatic logic [NN-1:0] make_syn(input logic [N-1:0] f);
    logic [NN-1:0] v;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        int d;
        d = (j - i + N) % N;
        if (!f[i] && d >= 1 && d <= T) v[i*N+j] = f[j];
        else v[i*N+j] = $urandom % 2;
      end
    return v;
  endfunction

  task automatic run(input logic [NN-1:0] v, output int lat);
    @(negedge clk);
    verdicts = v;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    do begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end while (!done && lat < 200);
    if (!done) check(0, "R6", "search hung", lat, LAT);
  endtask

  initial begin
    #(100000 * 10);
    n_tests++; n_fail++;
    $display("FAIL R6 watchdog expired: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int lat;
    logic [N-1:0] rm;
    bit rnf, ram;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 0 && faulty == 0 && none_found == 0 && ambiguous == 0,
          "R9", "reset outputs", {faulty, done, none_found, ambiguous}, 0);

    for (int e = 0; e < 5; e++) begin
      run(TV_VERD[e], lat);
      check(lat == LAT, "R6", "latency", lat, LAT);
      check(faulty == TV_MAP[e], "R1/R2/R3", "table bitmap", faulty, TV_MAP[e]);
      check(none_found == TV_NONE[e], "R4", "table no-fit flag", none_found, TV_NONE[e]);
      check(ambiguous == 0, "R5", "table ambiguous", ambiguous, 0);
    end

    // Every single and double fault set, faulty testers randomised.
    for (int mk = 1; mk < (1 << N); mk++) begin
      logic [N-1:0] f;
      f = mk[N-1:0];
      if ($countones(f) > T) continue;
      for (int r = 0; r < 3; r++) begin
        logic [NN-1:0] v;
        v = make_syn(f);
        run(v, lat);
        ref_eval(v, rm, rnf, ram);
        check(faulty == f, "R1", "fault set bitmap", faulty, f);
        check(faulty == rm, "R3", "bitmap vs model", faulty, rm);
        check(none_found == 0 && ambiguous == 0, "R5", "flags on legal syndrome",
              {none_found, ambiguous}, 0);
      end
    end

    // Triple faults go beyond T: compare with the model.
    for (int mk = 0; mk < (1 << N); mk++) begin
      logic [N-1:0] f;
      logic [NN-1:0] v;
      f = mk[N-1:0];
      if ($countones(f) != 3) continue;
      v = make_syn(f);
      run(v, lat);
      ref_eval(v, rm, rnf, ram);
      check(faulty == rm && none_found == rnf, "R4", "triple fault vs model",
            {faulty, none_found}, {rm, rnf});
      check(ambiguous == ram, "R5", "triple fault ambiguous", ambiguous, ram);
    end

    // Done lasts one cycle and results hold afterwards.
    run(TV_VERD[2], lat);
    @(negedge clk);
    check(done == 0, "R6", "done width", done, 0);
    repeat (5) @(negedge clk);
    check(faulty == 5'b00001 && none_found == 0, "R8", "held result",
          {faulty, none_found}, {5'b00001, 1'b0});

    // Mid-search start and matrix change are ignored.
    @(negedge clk);
    verdicts = TV_VERD[2];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    repeat (4) begin @(posedge clk); lat++; @(negedge clk); end
    verdicts = TV_VERD[1];
    start = 1'b1;
    @(posedge clk); lat++; @(negedge clk);
    start = 1'b0;
    while (!done && lat < 200) begin @(posedge clk); lat++; @(negedge clk); end
    check(lat == LAT + 1, "R7", "latency with extra start", lat, LAT + 1);
    check(faulty == 5'b00001 && none_found == 0, "R7", "result after disturbance",
          {faulty, none_found}, {5'b00001, 1'b0});

    // Matrix change after the accepting edge with no extra start.
    @(negedge clk);
    verdicts = TV_VERD[1];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    verdicts = TV_VERD[0];
    lat = 0;
    do begin @(posedge clk); lat++; @(negedge clk); end while (!done && lat < 200);
    check(none_found == 1 && faulty == 0, "R4", "captured all-fail matrix",
          {faulty, none_found}, {5'b00000, 1'b1});

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule